// File: doc/BRIEF.md
# Descriptor table fetch unit

This unit turns a 16-bit segment selector into the raw descriptor stored for it in one of two in-memory descriptor tables. The selector's table-indicator bit picks either the global table or the local table. The entry index is bounds-checked against that table's limit. On success the unit reads one 64-bit word, or two consecutive words for the long 16-byte system form, through a simple request/response memory port. It returns the words as 32-bit halves.

Every request carries a mode bit. In faulting mode a rejected lookup raises a fault with a caller-chosen vector and an error code derived from the selector. In probe mode the same rejection only clears the success flag. A third operation writes back the "accessed" attribute bit: given the attribute byte already held by the caller, it stores that byte with bit 0 set into byte 5 of the table entry. It skips the write when the bit is already set. One operation runs at a time, and the unit accepts a new one only while idle.

Top module: `dtf_fetch_unit`

## Requirements
- R1: The selector splits into index = bits [15:3], table indicator = bit 2 and requested privilege = bits [1:0]. Indicator 0 selects the global table (gdtBase/gdtLimit) and 1 selects the local table (ldtBase/ldtLimit/ldtValid). The first read address is table base + index*8, and the privilege bits have no effect on it.
- R2: Let the last byte be index*8+7 for an 8-byte fetch or index*8+15 for a 16-byte fetch, computed 32 bits wide so it never wraps. A global-table fetch is rejected when the last byte is greater than gdtLimit.
- R3: A local-table fetch is rejected whenever ldtValid is 0, whatever the limit. It is also rejected when the last byte is greater than ldtLimit. The global-table bounds play no part in a local-table fetch, and the reverse also holds.
- R4: A lookup rejected by bounds issues no memory request, and doneValid rises in the cycle right after the request is accepted.
- R5: Operation code reqOp = 2'b00 (also 2'b11) is an 8-byte fetch: exactly one read, with descLo = read data [31:0] and descHi = read data [63:32].
- R6: reqOp = 2'b01 is a 16-byte fetch. It reads address A and then A+8, and the second read is issued only after the first has returned. descExt = second word [31:0]. The fetch is rejected when bits [44:40] of the second word are not all zero.
- R7: In faulting mode (reqProbe = 0) a rejection pulses faultRaise with doneValid and doneOk = 0. faultNum equals the reqExcNo given with the request, and faultCode equals the selector AND 16'hFFFC.
- R8: In probe mode (reqProbe = 1) faultRaise stays low, and a rejection shows only as doneOk = 0.
- R9: descLo, descHi and descExt are zero unless doneValid and doneOk are both high. descExt is zero after a successful 8-byte fetch.
- R10: reqOp = 2'b10 is the accessed-bit write-back, and it has no bounds check. If reqAttr[0] is 0, it writes the single byte reqAttr | 8'h01 to (table chosen by the indicator) base + index*8 + 5. If reqAttr[0] is 1, it makes no memory access. Either way it completes with doneOk = 1.
- R11: Once memReqValid is high it stays high, with memAddr, memReqWrite and memWdata unchanged, until the cycle in which memReqReady is high.
- R12: reqReady is high only while the unit is idle, and doneValid is a single-cycle pulse per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Operation request |
| reqReady | output | 1 | Unit idle, request taken this cycle |
| reqOp | input | 2 | 00/11 8-byte fetch, 01 16-byte fetch, 10 accessed write-back |
| reqSel | input | 16 | Selector |
| reqProbe | input | 1 | 1 = report failure by flag only |
| reqExcNo | input | 8 | Fault vector for faulting mode |
| reqAttr | input | 8 | Current attribute byte for write-back |
| gdtBase | input | 32 | Global table base address |
| gdtLimit | input | 32 | Global table limit |
| ldtValid | input | 1 | Local table usable |
| ldtBase | input | 32 | Local table base address |
| ldtLimit | input | 32 | Local table scaled limit |
| memReqValid | output | 1 | Memory request |
| memReqReady | input | 1 | Memory accepts request |
| memReqWrite | output | 1 | 1 = byte write, 0 = 64-bit read |
| memAddr | output | 32 | Byte address |
| memWdata | output | 8 | Write byte |
| memRspValid | input | 1 | Read data returned |
| memRdata | input | 64 | Read data |
| doneValid | output | 1 | Operation complete pulse |
| doneOk | output | 1 | Operation succeeded |
| faultRaise | output | 1 | Fault raised (faulting mode) |
| faultNum | output | 8 | Fault vector |
| faultCode | output | 16 | Fault error code |
| descLo | output | 32 | Descriptor low dword |
| descHi | output | 32 | Descriptor high dword |
| descExt | output | 32 | Low dword of second word (16-byte fetch) |

## Verification
The bounds decision and the completion report share the acceptance window. A rejected lookup is resolved in the cycle the request is taken, and its done pulse, flag and fault fields appear in the very next cycle with no memory traffic in between. A sweep over table choice, LDT validity, three limits, ten indices, both widths and both modes provokes this on every limit edge. Each case is judged by the done latency, the read counter staying unchanged and the fault fields. A second overlap is a returning read response that triggers the next read: the behavioural memory varies its ready pattern and latency by address, and the bench checks the order and spacing of the two read addresses.

// File: rtl/dtf_pkg.sv
package dtf_pkg;

  localparam int QWORD_W     = 64;
  localparam int DWORD_W     = 32;
  localparam int BYTE_W      = 8;
  localparam int QWORD_BYTES = 8;
  localparam int ACC_OFFSET  = 5;
  localparam int EXT_LO      = 40;
  localparam int EXT_HI      = 44;

  localparam logic [1:0] OP_SHORT = 2'b00;
  localparam logic [1:0] OP_LONG  = 2'b01;
  localparam logic [1:0] OP_MARK  = 2'b10;

  function automatic logic opIsLong(input logic [1:0] op);
    return op == OP_LONG;
  endfunction

  function automatic logic opIsMark(input logic [1:0] op);
    return op == OP_MARK;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD0_REQ,
    ST_RD0_WAIT,
    ST_RD1_REQ,
    ST_RD1_WAIT,
    ST_WR_REQ,
    ST_FIN
  } dtfState_t;

  // strobes from control into datapath
  typedef struct packed {
    logic latch;
    logic capFirst;
    logic stepAddr;
    logic capSecond;
  } dtfCtl_t;

  // status from datapath back to control
  typedef struct packed {
    logic boundsFail;
    logic failed;
    logic probe;
  } dtfStat_t;

endpackage

// File: rtl/dtf_bounds.sv
module dtf_bounds #(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 32,
  parameter int SEL_W  = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic              longFetch,
  input  logic [ADDR_W-1:0] gdtBase,
  input  logic [LIM_W-1:0]  gdtLimit,
  input  logic              ldtValid,
  input  logic [ADDR_W-1:0] ldtBase,
  input  logic [LIM_W-1:0]  ldtLimit,
  output logic              outOfBounds,
  output logic [ADDR_W-1:0] entryAddr
);
  localparam int NUM_TBL = 2;
  localparam int IDX_W   = SEL_W - 3;
  localparam int SPAN_W  = IDX_W + 3;
  localparam int TI_BIT  = 2;

  logic [SPAN_W-1:0] entryOffs;
  logic [LIM_W-1:0]  lastByte;
  logic              tableSel;

  logic [ADDR_W-1:0] tblBase [NUM_TBL];
  logic [LIM_W-1:0]  tblLim  [NUM_TBL];
  logic [NUM_TBL-1:0] tblUsable;
  logic [NUM_TBL-1:0] tblFail;

  assign entryOffs = {sel[SEL_W-1:3], 3'b000};
  assign lastByte  = LIM_W'(entryOffs) +
                     (longFetch ? LIM_W'(2*QW_BYTES_L-1) : LIM_W'(QW_BYTES_L-1));
  assign tableSel  = sel[TI_BIT];

  localparam int QW_BYTES_L = 8;

  assign tblBase[0] = gdtBase;
  assign tblBase[1] = ldtBase;
  assign tblLim[0]  = gdtLimit;
  assign tblLim[1]  = ldtLimit;
  assign tblUsable  = {ldtValid, 1'b1};

  // one independent check per table
  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    assign tblFail[t] = !tblUsable[t] || (lastByte > tblLim[t]);
  end

  assign outOfBounds = tblFail[tableSel];
  assign entryAddr   = tblBase[tableSel] + ADDR_W'(entryOffs);

endmodule

// File: rtl/dtf_datapath.sv
module dtf_datapath
  import dtf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 32,
  parameter int SEL_W  = 16,
  parameter int EXC_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dtfCtl_t             ctl,
  input  logic [1:0]          reqOp,
  input  logic [SEL_W-1:0]    reqSel,
  input  logic                reqProbe,
  input  logic [EXC_W-1:0]    reqExcNo,
  input  logic [BYTE_W-1:0]   reqAttr,
  input  logic [ADDR_W-1:0]   gdtBase,
  input  logic [LIM_W-1:0]    gdtLimit,
  input  logic                ldtValid,
  input  logic [ADDR_W-1:0]   ldtBase,
  input  logic [LIM_W-1:0]    ldtLimit,
  input  logic [QWORD_W-1:0]  memRdata,
  output dtfStat_t            stat,
  output logic [ADDR_W-1:0]   addrQ,
  output logic [BYTE_W-1:0]   wdataQ,
  output logic [EXC_W-1:0]    excQ,
  output logic [SEL_W-1:0]    codeQ,
  output logic [DWORD_W-1:0]  loQ,
  output logic [DWORD_W-1:0]  hiQ,
  output logic [DWORD_W-1:0]  extQ
);
  logic              outOfBounds;
  logic [ADDR_W-1:0] entryAddr;
  logic              isMark;
  logic              isLong;
  logic              failQ;
  logic              probeQ;
  logic [SEL_W-1:0]  selQ;
  logic              extNonZero;

  assign isMark     = opIsMark(reqOp);
  assign isLong     = opIsLong(reqOp);
  assign extNonZero = |memRdata[EXT_HI:EXT_LO];

  dtf_bounds #(
    .ADDR_W(ADDR_W), .LIM_W(LIM_W), .SEL_W(SEL_W)
  ) u_bounds (
    .sel        (reqSel),
    .longFetch  (isLong),
    .gdtBase    (gdtBase),
    .gdtLimit   (gdtLimit),
    .ldtValid   (ldtValid),
    .ldtBase    (ldtBase),
    .ldtLimit   (ldtLimit),
    .outOfBounds(outOfBounds),
    .entryAddr  (entryAddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addrQ  <= '0;
      wdataQ <= '0;
      excQ   <= '0;
      selQ   <= '0;
      probeQ <= 1'b0;
      failQ  <= 1'b0;
      loQ    <= '0;
      hiQ    <= '0;
      extQ   <= '0;
    end else begin
      if (ctl.latch) begin
        selQ   <= reqSel;
        excQ   <= reqExcNo;
        probeQ <= reqProbe;
        wdataQ <= reqAttr | BYTE_W'(1);
        addrQ  <= isMark ? entryAddr + ADDR_W'(ACC_OFFSET) : entryAddr;
        failQ  <= !isMark && outOfBounds;
        loQ    <= '0;
        hiQ    <= '0;
        extQ   <= '0;
      end
      if (ctl.capFirst) begin
        loQ <= memRdata[DWORD_W-1:0];
        hiQ <= memRdata[QWORD_W-1:DWORD_W];
      end
      if (ctl.stepAddr) begin
        addrQ <= addrQ + ADDR_W'(QWORD_BYTES);
      end
      if (ctl.capSecond) begin
        extQ  <= memRdata[DWORD_W-1:0];
        failQ <= failQ | extNonZero;
      end
    end
  end

  assign codeQ = selQ & ~SEL_W'(3);
  assign stat  = '{boundsFail: outOfBounds, failed: failQ, probe: probeQ};

  // R3: an unusable local table always rejects a fetch
  a_r3_ldt_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.latch && reqSel[2] && !ldtValid && !isMark) |=> stat.failed);

  // R6: a nonzero type field in the upper word rejects the fetch
  a_r6_ext_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.capSecond && extNonZero) |=> stat.failed);

endmodule

// File: rtl/dtf_ctrl.sv
module dtf_ctrl
  import dtf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       attrMarked,
  input  dtfStat_t   stat,
  input  logic       memReqReady,
  input  logic       memRspValid,
  output dtfCtl_t    ctl,
  output logic       reqReady,
  output logic       memReqValid,
  output logic       memReqWrite,
  output logic       doneValid,
  output logic       doneOk,
  output logic       faultRaise
);
  dtfState_t state, stateNxt;
  logic      longQ;

  always_comb begin
    stateNxt    = state;
    ctl         = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    memReqWrite = 1'b0;
    doneValid   = 1'b0;
    doneOk      = 1'b0;
    faultRaise  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.latch = 1'b1;
          if (opIsMark(reqOp))
            stateNxt = attrMarked ? ST_FIN : ST_WR_REQ;
          else
            stateNxt = stat.boundsFail ? ST_FIN : ST_RD0_REQ;
        end
      end
      ST_RD0_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNxt = ST_RD0_WAIT;
      end
      ST_RD0_WAIT: begin
        if (memRspValid) begin
          ctl.capFirst = 1'b1;
          if (longQ) begin
            ctl.stepAddr = 1'b1;
            stateNxt     = ST_RD1_REQ;
          end else begin
            stateNxt = ST_FIN;
          end
        end
      end
      ST_RD1_REQ: begin
        memReqValid = 1'b1;
        if (memReqReady) stateNxt = ST_RD1_WAIT;
      end
      ST_RD1_WAIT: begin
        if (memRspValid) begin
          ctl.capSecond = 1'b1;
          stateNxt      = ST_FIN;
        end
      end
      ST_WR_REQ: begin
        memReqValid = 1'b1;
        memReqWrite = 1'b1;
        if (memReqReady) stateNxt = ST_FIN;
      end
      ST_FIN: begin
        doneValid  = 1'b1;
        doneOk     = !stat.failed;
        faultRaise = stat.failed && !stat.probe;
        stateNxt   = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      longQ <= 1'b0;
    end else begin
      state <= stateNxt;
      if (ctl.latch) longQ <= opIsLong(reqOp);
    end
  end

  // R12: completion lasts exactly one cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    doneValid |=> !doneValid);

  // R12: no memory traffic while idle
  a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !memReqValid);

  // R4: a bounds rejection completes in the next cycle, unsuccessfully
  a_r4_fail_fast: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady && !opIsMark(reqOp) && stat.boundsFail) |=> (doneValid && !doneOk));

  // R8: probe mode never raises a fault
  a_r8_probe_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (doneValid && stat.probe) |-> !faultRaise);

endmodule

// File: rtl/dtf_fetch_unit.sv
module dtf_fetch_unit
  import dtf_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 32,
  parameter int SEL_W  = 16,
  parameter int EXC_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [1:0]          reqOp,
  input  logic [SEL_W-1:0]    reqSel,
  input  logic                reqProbe,
  input  logic [EXC_W-1:0]    reqExcNo,
  input  logic [7:0]          reqAttr,
  input  logic [ADDR_W-1:0]   gdtBase,
  input  logic [LIM_W-1:0]    gdtLimit,
  input  logic                ldtValid,
  input  logic [ADDR_W-1:0]   ldtBase,
  input  logic [LIM_W-1:0]    ldtLimit,
  output logic                memReqValid,
  input  logic                memReqReady,
  output logic                memReqWrite,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [7:0]          memWdata,
  input  logic                memRspValid,
  input  logic [63:0]         memRdata,
  output logic                doneValid,
  output logic                doneOk,
  output logic                faultRaise,
  output logic [EXC_W-1:0]    faultNum,
  output logic [SEL_W-1:0]    faultCode,
  output logic [31:0]         descLo,
  output logic [31:0]         descHi,
  output logic [31:0]         descExt
);
  dtfCtl_t            ctl;
  dtfStat_t           stat;
  logic [EXC_W-1:0]   excQ;
  logic [SEL_W-1:0]   codeQ;
  logic [DWORD_W-1:0] loQ, hiQ, extQ;
  logic               passOut;

  dtf_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .reqValid   (reqValid),
    .reqOp      (reqOp),
    .attrMarked (reqAttr[0]),
    .stat       (stat),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .memReqWrite(memReqWrite),
    .doneValid  (doneValid),
    .doneOk     (doneOk),
    .faultRaise (faultRaise)
  );

  dtf_datapath #(
    .ADDR_W(ADDR_W), .LIM_W(LIM_W), .SEL_W(SEL_W), .EXC_W(EXC_W)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl     (ctl),
    .reqOp   (reqOp),
    .reqSel  (reqSel),
    .reqProbe(reqProbe),
    .reqExcNo(reqExcNo),
    .reqAttr (reqAttr),
    .gdtBase (gdtBase),
    .gdtLimit(gdtLimit),
    .ldtValid(ldtValid),
    .ldtBase (ldtBase),
    .ldtLimit(ldtLimit),
    .memRdata(memRdata),
    .stat    (stat),
    .addrQ   (memAddr),
    .wdataQ  (memWdata),
    .excQ    (excQ),
    .codeQ   (codeQ),
    .loQ     (loQ),
    .hiQ     (hiQ),
    .extQ    (extQ)
  );

  assign passOut   = doneValid && doneOk;
  assign descLo    = passOut ? loQ  : '0;
  assign descHi    = passOut ? hiQ  : '0;
  assign descExt   = passOut ? extQ : '0;
  assign faultNum  = faultRaise ? excQ  : '0;
  assign faultCode = faultRaise ? codeQ : '0;

  // R11: a pending request holds still until taken
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && !memReqReady) |=>
      (memReqValid && $stable(memAddr) && $stable(memReqWrite) && $stable(memWdata)));

  // R10: every write-back carries the accessed bit
  a_r10_mark_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (memReqValid && memReqWrite) |-> memWdata[0]);

  // R7: a raised fault always accompanies an unsuccessful completion
  a_r7_fault_done: assert property (@(posedge clk) disable iff (!rst_n)
    faultRaise |-> (doneValid && !doneOk));

endmodule

// File: tb/dtf_fetch_unit_test.sv
`timescale 1ns/100ps
module dtf_fetch_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [1:0]  reqOp = 2'b00;
  logic [15:0] reqSel = '0;
  logic        reqProbe = 1'b0;
  logic [7:0]  reqExcNo = '0;
  logic [7:0]  reqAttr = '0;
  logic [31:0] gdtBase = 32'h0;
  logic [31:0] gdtLimit = '0;
  logic        ldtValid = 1'b0;
  logic [31:0] ldtBase = 32'h200;
  logic [31:0] ldtLimit = '0;
  logic        memReqValid, memReqWrite;
  logic        memReqReady;
  logic [31:0] memAddr;
  logic [7:0]  memWdata;
  logic        memRspValid;
  logic [63:0] memRdata;
  logic        doneValid, doneOk, faultRaise;
  logic [7:0]  faultNum;
  logic [15:0] faultCode;
  logic [31:0] descLo, descHi, descExt;

  int tests = 0;
  int failed = 0;

  always #2.5 clk = ~clk;

  dtf_fetch_unit uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqSel(reqSel), .reqProbe(reqProbe), .reqExcNo(reqExcNo),
    .reqAttr(reqAttr), .gdtBase(gdtBase), .gdtLimit(gdtLimit),
    .ldtValid(ldtValid), .ldtBase(ldtBase), .ldtLimit(ldtLimit),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqWrite(memReqWrite),
    .memAddr(memAddr), .memWdata(memWdata), .memRspValid(memRspValid),
    .memRdata(memRdata), .doneValid(doneValid), .doneOk(doneOk),
    .faultRaise(faultRaise), .faultNum(faultNum), .faultCode(faultCode),
    .descLo(descLo), .descHi(descHi), .descExt(descExt)
  );

  // ---------------- behavioural memory ----------------
  function automatic logic [63:0] memInit(input int k);
    logic [7:0] kk;
    logic [4:0] fld;
    kk  = k[7:0];
    fld = (kk[1:0] == 2'b00) ? 5'd0 : {3'b000, kk[1:0]};
    return {kk ^ 8'hC3, 11'h000, fld, 8'h5A, 16'h1234, kk, 8'h00};
  endfunction

  logic [63:0] mem [0:127];
  logic [1:0]  rdyPhase;
  logic        pend;
  logic [1:0]  pendCnt;
  logic [63:0] pendData;
  int          rdTotal, wrTotal;
  logic [31:0] rdLog [0:3];

  assign memReqReady = (rdyPhase != 2'd1);
  assign memRspValid = pend && (pendCnt == 2'd0);
  assign memRdata    = pendData;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 128; k++) mem[k] <= memInit(k);
      rdyPhase <= 2'd0;
      pend     <= 1'b0;
      pendCnt  <= 2'd0;
      pendData <= '0;
      rdTotal  <= 0;
      wrTotal  <= 0;
      for (int k = 0; k < 4; k++) rdLog[k] <= '0;
    end else begin
      rdyPhase <= rdyPhase + 2'd1;
      if (memRspValid) pend <= 1'b0;
      else if (pend && pendCnt != 2'd0) pendCnt <= pendCnt - 2'd1;
      if (memReqValid && memReqReady) begin
        if (memReqWrite) begin
          mem[memAddr[9:3]][memAddr[2:0]*8 +: 8] <= memWdata;
          wrTotal <= wrTotal + 1;
        end else begin
          pend     <= 1'b1;
          pendCnt  <= (memAddr[4:3] == 2'd3) ? 2'd0 : memAddr[4:3];
          pendData <= mem[memAddr[9:3]];
          rdLog[rdTotal & 3] <= memAddr;
          rdTotal  <= rdTotal + 1;
        end
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chkEq(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic        gOk, gFault;
  logic [7:0]  gNum;
  logic [15:0] gCode;
  logic [31:0] gLo, gHi, gExt, gRd0, gRd1;
  int          gRd, gWr, gLat;

  task automatic runOp(input logic [1:0] op, input logic [15:0] sel,
                       input logic probe, input logic [7:0] exc, input logic [7:0] attr);
    int sRd, sWr, cnt;
    @(negedge clk);
    reqOp = op; reqSel = sel; reqProbe = probe; reqExcNo = exc; reqAttr = attr;
    reqValid = 1'b1;
    sRd = rdTotal; sWr = wrTotal;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cnt = 1;
    while (!doneValid && cnt < 60) begin
      @(negedge clk);
      cnt++;
    end
    if (!doneValid) begin
      tests++; failed++;
      $display("FAIL R12 completion timeout: actual 0 expected 1");
    end
    gLat = cnt; gOk = doneOk; gFault = faultRaise; gNum = faultNum; gCode = faultCode;
    gLo = descLo; gHi = descHi; gExt = descExt;
    gRd = rdTotal - sRd; gWr = wrTotal - sWr;
    gRd0 = rdLog[sRd & 3]; gRd1 = rdLog[(sRd + 1) & 3];
  endtask

  // common judgement of a fetch result
  task automatic judgeFetch(input string req, input logic [15:0] sel, input logic isLong,
                            input logic probe, input logic [7:0] exc,
                            input logic bFail, input logic [31:0] addr, input int qk);
    logic [63:0] q0, q1;
    logic        extFail, expOk;
    q0 = memInit(qk);
    q1 = memInit(qk + 1);
    extFail = isLong && (q1[44:40] != 5'd0);
    expOk   = !bFail && !extFail;
    chkEq(req, "doneOk", gOk, expOk);
    if (bFail) begin
      chkEq("R4", "latency", gLat, 1);
      chkEq("R4", "reads", gRd, 0);
    end else begin
      chkEq("R6", "read count", gRd, isLong ? 2 : 1);
      chkEq("R1", "first addr", gRd0, addr);
      if (isLong) chkEq("R6", "second addr", gRd1, addr + 32'd8);
    end
    if (probe) chkEq("R8", "no fault", gFault, 1'b0);
    else       chkEq("R7", "fault", gFault, !expOk);
    if (!expOk && !probe) begin
      chkEq("R7", "fault vector", gNum, exc);
      chkEq("R7", "fault code", gCode, sel & 16'hFFFC);
    end
    if (expOk) begin
      chkEq("R5", "desc lo", gLo, q0[31:0]);
      chkEq("R5", "desc hi", gHi, q0[63:32]);
      chkEq("R6", "desc ext", gExt, isLong ? q1[31:0] : 32'h0);
    end else begin
      chkEq("R9", "desc zero", {gLo, gHi} | {32'h0, gExt}, 64'h0);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] lims [0:2];
    lims[0] = 32'h17; lims[1] = 32'h2F; lims[2] = 32'h4F;

    repeat (4) @(posedge clk);
    @(negedge clk);
    chkEq("R12", "reset ready", reqReady, 1'b1);
    chkEq("R12", "reset done", doneValid, 1'b0);
    chkEq("R11", "reset memReq", memReqValid, 1'b0);
    rst_n = 1'b1;

    // global-table sweep (R2), local table unusable and tiny
    ldtValid = 1'b0; ldtLimit = 32'h0;
    for (int li = 0; li < 3; li++) begin
      gdtLimit = lims[li];
      for (int idx = 0; idx < 10; idx++) begin
        for (int w = 0; w < 2; w++) begin
          for (int p = 0; p < 2; p++) begin
            logic [15:0] sel;
            int last;
            sel  = {idx[12:0], 1'b0, idx[1:0]};
            last = idx * 8 + (w != 0 ? 15 : 7);
            runOp(w != 0 ? 2'b01 : (idx[0] ? 2'b11 : 2'b00), sel, p[0], 8'h0D ^ idx[7:0], 8'h0);
            judgeFetch("R2", sel, w[0], p[0], 8'h0D ^ idx[7:0],
                       last > int'(lims[li]), idx * 8, idx);
          end
        end
      end
    end

    // local-table sweep (R3), global table of zero size
    gdtLimit = 32'h0;
    for (int v = 0; v < 2; v++) begin
      ldtValid = v[0];
      for (int li = 0; li < 3; li++) begin
        ldtLimit = lims[li];
        for (int idx = 0; idx < 10; idx++) begin
          for (int w = 0; w < 2; w++) begin
            for (int p = 0; p < 2; p++) begin
              logic [15:0] sel;
              int last;
              sel  = {idx[12:0], 1'b1, ~idx[1:0]};
              last = idx * 8 + (w != 0 ? 15 : 7);
              runOp(w != 0 ? 2'b01 : 2'b00, sel, p[0], 8'h0B + idx[7:0], 8'h0);
              judgeFetch("R3", sel, w[0], p[0], 8'h0B + idx[7:0],
                         (v == 0) || (last > int'(lims[li])), 32'h200 + idx * 8, 64 + idx);
            end
          end
        end
      end
    end

    // R2: large index must not wrap the limit arithmetic
    gdtLimit = 32'h0000_FFFF;
    runOp(2'b00, 16'hFFF8, 1'b0, 8'h0D, 8'h0);
    judgeFetch("R2", 16'hFFF8, 1'b0, 1'b0, 8'h0D, 1'b0, 32'hFFF8, 127);
    runOp(2'b01, 16'hFFF8, 1'b0, 8'h0D, 8'h0);
    judgeFetch("R2", 16'hFFF8, 1'b1, 1'b0, 8'h0D, 1'b1, 32'hFFF8, 127);

    // R10: accessed-bit write-back
    gdtLimit = 32'h4F; ldtLimit = 32'h4F; ldtValid = 1'b1;
    begin
      logic [63:0] q;
      // global table, bit clear -> one byte write
      runOp(2'b10, {13'd3, 1'b0, 2'b01}, 1'b0, 8'h0, 8'h92);
      chkEq("R10", "gdt write count", gWr, 1);
      chkEq("R10", "gdt no read", gRd, 0);
      chkEq("R10", "gdt done ok", gOk, 1'b1);
      runOp(2'b00, {13'd3, 1'b0, 2'b00}, 1'b1, 8'h0, 8'h0);
      q = memInit(3);
      chkEq("R10", "gdt byte5", gHi, {q[63:48], 8'h93, q[39:32]});
      chkEq("R10", "gdt lo kept", gLo, q[31:0]);

      // local table with unusable flag: no bounds check, still writes
      ldtValid = 1'b0;
      runOp(2'b10, {13'd5, 1'b1, 2'b11}, 1'b0, 8'h0, 8'hF2);
      chkEq("R10", "ldt write count", gWr, 1);
      chkEq("R10", "ldt done ok", gOk, 1'b1);
      ldtValid = 1'b1;
      runOp(2'b00, {13'd5, 1'b1, 2'b00}, 1'b1, 8'h0, 8'h0);
      q = memInit(69);
      chkEq("R10", "ldt byte5", gHi, {q[63:48], 8'hF3, q[39:32]});

      // bit already set: no memory access, entry unchanged
      runOp(2'b10, {13'd4, 1'b0, 2'b00}, 1'b0, 8'h0, 8'h93);
      chkEq("R10", "marked no write", gWr, 0);
      chkEq("R10", "marked no read", gRd, 0);
      chkEq("R10", "marked done ok", gOk, 1'b1);
      runOp(2'b00, {13'd4, 1'b0, 2'b00}, 1'b1, 8'h0, 8'h0);
      q = memInit(4);
      chkEq("R10", "marked entry kept", gHi, q[63:32]);
    end

    @(negedge clk);
    chkEq("R12", "idle after ops", reqReady, 1'b1);
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    tests++; failed++;
    $display("FAIL R12 watchdog expired: actual running expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule